// File: doc/BRIEF.md
# Block Write-Lock Command Decoder

This block watches the stream of byte loads that a bus front end hands to a paged, non-volatile memory. It picks out two fixed command sequences made of data bytes at particular addresses. The three-byte unlock key opens the current write burst and can arm protection for one block. The six-byte release sequence removes protection from one block. It holds one lock bit per memory block and tells the storage side, load by load, whether a byte may be committed.

The memory array and the write-period timers sit outside this block. A burst is the set of loads between two end-of-write strobes. Lock changes requested during a burst are held pending and applied on the strobe, whether or not any data bytes followed the command. Only the low fifteen address bits take part in command matching. The topmost address bits pick the block.

Top module: `swpCmdDecoder`

## Requirements
- R1: After reset every bit of `blockProt` is 0 and `writeAllowed` is 0.
- R2: When the first three loads of a burst are 0xAA at low address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555, `writeAllowed` is 1 from the cycle after the third load until the burst ends. The block addressed by the third load becomes locked (its `blockProt` bit reads 1) in the cycle after `writeEnd`.
- R3: When the first six loads of a burst are 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x20@0x5555, `writeAllowed` is 1 for the rest of the burst. The block addressed by the sixth load is unlocked in the cycle after `writeEnd`.
- R4: Command matching uses only address bits [14:0]. The block index is the top `BLOCK_W` address bits, so command bytes may carry any block index, and only the final byte's block is the target.
- R5: A load consumed as part of a command sequence, whether complete or partial, never raises `commitOk`.
- R6: In a burst without a complete key, a data load raises `commitOk` in the same cycle if its block is unlocked, and leaves it 0 if its block is locked.
- R7: In a burst that began with a complete key (R2 or R3), every data load raises `commitOk`, whatever its block.
- R8: A load that departs from the expected sequence is judged as a data load under R6. Command recognition then stays off until the burst ends, so a later key in the same burst counts as plain data.
- R9: `blockProt` changes only in the cycle after `writeEnd`. A burst ended in the middle of a sequence changes nothing. `writeAllowed` is 0 in the cycle after `writeEnd`.
- R10: Each block's lock bit is independent: one strobe changes at most one bit, and any combination of locked blocks can be built up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; clears all lock bits |
| loadValid | input | 1 | One byte load is presented this cycle |
| loadAddr | input | ADDR_W | Address of the load; top BLOCK_W bits are the block index |
| loadData | input | 8 | Data byte of the load |
| writeEnd | input | 1 | End of the write period; closes the burst |
| commitOk | output | 1 | The presented load may be stored (combinational) |
| writeAllowed | output | 1 | The current burst opened with a complete key |
| blockProt | output | 2**BLOCK_W | Lock bit of each block |

## Verification
The bench builds the decoder with ADDR_W = 18 and BLOCK_W = 3. That gives eight lock bits, so many lock patterns can be reached, and a three-bit block field sits directly above the fifteen compare bits. Random bursts mix keys, release sequences, deliberately broken prefixes and data bytes that collide with the command values. This brings broken-then-retried sequences and commands spread across several block indices within reach, next to directed cases for mid-sequence burst ends and key-only bursts.

// File: rtl/swpPkg.sv
package swpPkg;

  localparam int CMP_W = 15;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_LOCK    = 8'hA0;
  localparam logic [7:0] OP_RELEASE = 8'h80;
  localparam logic [7:0] OP_FREE    = 8'h20;

  localparam logic [CMP_W-1:0] ADR_UPPER = 15'h5555;
  localparam logic [CMP_W-1:0] ADR_LOWER = 15'h2AAA;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_GOT_A,
    PH_GOT_B,
    PH_REL_1,
    PH_REL_2,
    PH_REL_3,
    PH_OPEN,
    PH_FREED,
    PH_PLAIN
  } seqPhase_t;

  typedef struct packed {
    logic dataLoad;
    logic armSet;
    logic armClr;
    logic unlocked;
    logic endWrite;
  } ctrlStrobe_t;

endpackage

// File: rtl/swpKeyMatch.sv
module swpKeyMatch
  import swpPkg::*;
(
  input  logic [CMP_W-1:0] loadLow,
  input  logic [7:0]       loadData,
  output logic             isFirst,
  output logic             isSecond,
  output logic             isLock,
  output logic             isRelease,
  output logic             isFree
);

  logic atUpper;
  logic atLower;

  assign atUpper   = (loadLow == ADR_UPPER);
  assign atLower   = (loadLow == ADR_LOWER);

  assign isFirst   = atUpper && (loadData == KEY_FIRST);
  assign isSecond  = atLower && (loadData == KEY_SECOND);
  assign isLock    = atUpper && (loadData == OP_LOCK);
  assign isRelease = atUpper && (loadData == OP_RELEASE);
  assign isFree    = atUpper && (loadData == OP_FREE);

endmodule

// File: rtl/swpSeqCtrl.sv
module swpSeqCtrl
  import swpPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadValid,
  input  logic [CMP_W-1:0] loadLow,
  input  logic [7:0]       loadData,
  input  logic             writeEnd,
  output ctrlStrobe_t      strb
);

  seqPhase_t phase;
  seqPhase_t phaseNxt;
  logic      isFirst, isSecond, isLock, isRelease, isFree;
  logic      dataLoad, armSet, armClr;

  swpKeyMatch uMatch (
    .loadLow  (loadLow),
    .loadData (loadData),
    .isFirst  (isFirst),
    .isSecond (isSecond),
    .isLock   (isLock),
    .isRelease(isRelease),
    .isFree   (isFree)
  );

  always_comb begin
    phaseNxt = phase;
    dataLoad = 1'b0;
    armSet   = 1'b0;
    armClr   = 1'b0;
    if (loadValid) begin
      case (phase)
        PH_IDLE: begin
          if (isFirst) phaseNxt = PH_GOT_A;
          else begin dataLoad = 1'b1; phaseNxt = PH_PLAIN; end
        end
        PH_GOT_A: begin
          if (isSecond) phaseNxt = PH_GOT_B;
          else begin dataLoad = 1'b1; phaseNxt = PH_PLAIN; end
        end
        PH_GOT_B: begin
          if (isLock) begin
            phaseNxt = PH_OPEN;
            armSet   = 1'b1;
          end else if (isRelease) begin
            phaseNxt = PH_REL_1;
          end else begin
            dataLoad = 1'b1;
            phaseNxt = PH_PLAIN;
          end
        end
        PH_REL_1: begin
          if (isFirst) phaseNxt = PH_REL_2;
          else begin dataLoad = 1'b1; phaseNxt = PH_PLAIN; end
        end
        PH_REL_2: begin
          if (isSecond) phaseNxt = PH_REL_3;
          else begin dataLoad = 1'b1; phaseNxt = PH_PLAIN; end
        end
        PH_REL_3: begin
          if (isFree) begin
            phaseNxt = PH_FREED;
            armClr   = 1'b1;
          end else begin
            dataLoad = 1'b1;
            phaseNxt = PH_PLAIN;
          end
        end
        default: dataLoad = 1'b1;
      endcase
    end
    if (writeEnd) phaseNxt = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  always_comb begin
    strb.dataLoad = dataLoad;
    strb.armSet   = armSet;
    strb.armClr   = armClr;
    strb.unlocked = (phase == PH_OPEN) || (phase == PH_FREED);
    strb.endWrite = writeEnd;
  end

endmodule

// File: rtl/swpProtDatapath.sv
module swpProtDatapath
  import swpPkg::*;
#(
  parameter int BLOCK_W = 2,
  localparam int NUM_BLK = 1 << BLOCK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [BLOCK_W-1:0] loadBlk,
  output logic               commitOk,
  output logic [NUM_BLK-1:0] blockProt
);

  logic [NUM_BLK-1:0] prot;
  logic [NUM_BLK-1:0] pendSet;
  logic [NUM_BLK-1:0] pendClr;

  for (genvar b = 0; b < NUM_BLK; b++) begin : gBlk
    logic hitHere;
    assign hitHere = (loadBlk == BLOCK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prot[b]    <= 1'b0;
        pendSet[b] <= 1'b0;
        pendClr[b] <= 1'b0;
      end else if (strb.endWrite) begin
        prot[b]    <= (prot[b] | pendSet[b]) & ~pendClr[b];
        pendSet[b] <= 1'b0;
        pendClr[b] <= 1'b0;
      end else begin
        if (strb.armSet && hitHere) pendSet[b] <= 1'b1;
        if (strb.armClr && hitHere) pendClr[b] <= 1'b1;
      end
    end
  end

  assign commitOk  = strb.dataLoad && (strb.unlocked || !prot[loadBlk]);
  assign blockProt = prot;

endmodule

// File: rtl/swpCmdDecoder.sv
module swpCmdDecoder
  import swpPkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BLOCK_W = 2,
  localparam int NUM_BLK = 1 << BLOCK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadValid,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic [7:0]         loadData,
  input  logic               writeEnd,
  output logic               commitOk,
  output logic               writeAllowed,
  output logic [NUM_BLK-1:0] blockProt
);

  ctrlStrobe_t        strb;
  logic [CMP_W-1:0]   loadLow;
  logic [BLOCK_W-1:0] loadBlk;

  assign loadLow = loadAddr[CMP_W-1:0];
  assign loadBlk = loadAddr[ADDR_W-1 -: BLOCK_W];

  swpSeqCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadValid(loadValid),
    .loadLow  (loadLow),
    .loadData (loadData),
    .writeEnd (writeEnd),
    .strb     (strb)
  );

  swpProtDatapath #(.BLOCK_W(BLOCK_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadBlk  (loadBlk),
    .commitOk (commitOk),
    .blockProt(blockProt)
  );

  assign writeAllowed = strb.unlocked;

endmodule

// File: rtl/swpCmdChecker.sv
module swpCmdChecker #(
  parameter int BLOCK_W = 2,
  localparam int NUM_BLK = 1 << BLOCK_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadValid,
  input logic [BLOCK_W-1:0] loadBlk,
  input logic               writeEnd,
  input logic               commitOk,
  input logic               writeAllowed,
  input logic [NUM_BLK-1:0] blockProt
);

  // R6: a commit grant needs a load in the same cycle
  a_r6_commit_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    commitOk |-> loadValid);

  // R6: outside an opened burst a locked block is never granted
  a_r6_locked_refused: assert property (@(posedge clk) disable iff (!rstN)
    (commitOk && !writeAllowed) |-> !blockProt[loadBlk]);

  a_r9_prot_moves_on_end: assert property (@(posedge clk) disable iff (!rstN)
    !$past(writeEnd) |-> $stable(blockProt));

  a_r9_allow_drops: assert property (@(posedge clk) disable iff (!rstN)
    writeEnd |=> !writeAllowed);

  a_r10_one_bit_per_end: assert property (@(posedge clk) disable iff (!rstN)
    $countones(blockProt ^ $past(blockProt)) <= 1);

  a_r2_open_after_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeAllowed) |-> $past(loadValid));

endmodule

bind swpCmdDecoder swpCmdChecker #(.BLOCK_W(BLOCK_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .loadValid   (loadValid),
  .loadBlk     (loadAddr[ADDR_W-1 -: BLOCK_W]),
  .writeEnd    (writeEnd),
  .commitOk    (commitOk),
  .writeAllowed(writeAllowed),
  .blockProt   (blockProt)
);

// File: tb/tb_swpCmdDecoder.sv
`timescale 1ns/1ps
module tb_swpCmdDecoder;

  localparam int AW = 18;
  localparam int BW = 3;
  localparam int NB = 1 << BW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadValid = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [7:0]    loadData = '0;
  logic          writeEnd = 1'b0;
  logic          commitOk;
  logic          writeAllowed;
  logic [NB-1:0] blockProt;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // model of the requirements
  int          mPhase = 0;
  logic [NB-1:0] mProt = '0;
  logic [NB-1:0] mPendSet = '0;
  logic [NB-1:0] mPendClr = '0;

  always #2.5 clk = ~clk;

  swpCmdDecoder #(.ADDR_W(AW), .BLOCK_W(BW)) dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadAddr(loadAddr),
    .loadData(loadData), .writeEnd(writeEnd), .commitOk(commitOk),
    .writeAllowed(writeAllowed), .blockProt(blockProt)
  );

  function automatic logic [AW-1:0] mk(input int blk, input logic [14:0] low);
    return {blk[BW-1:0], low};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // phases: 0 idle, 1-2 key progress, 3-5 release progress, 6 open, 7 freed, 8 plain
  task automatic modelLoad(input logic [AW-1:0] a, input logic [7:0] d, output bit exp);
    logic [14:0] low = a[14:0];
    int blk = int'(a[AW-1 -: BW]);
    bit f = (low == 15'h5555) && (d == 8'hAA);
    bit s = (low == 15'h2AAA) && (d == 8'h55);
    bit up = (low == 15'h5555);
    bit isData = 0;
    bit unl = (mPhase == 6) || (mPhase == 7);
    case (mPhase)
      0: if (f) mPhase = 1; else begin isData = 1; mPhase = 8; end
      1: if (s) mPhase = 2; else begin isData = 1; mPhase = 8; end
      2: if (up && d == 8'hA0) begin mPhase = 6; mPendSet[blk] = 1'b1; end
         else if (up && d == 8'h80) mPhase = 3;
         else begin isData = 1; mPhase = 8; end
      3: if (f) mPhase = 4; else begin isData = 1; mPhase = 8; end
      4: if (s) mPhase = 5; else begin isData = 1; mPhase = 8; end
      5: if (up && d == 8'h20) begin mPhase = 7; mPendClr[blk] = 1'b1; end
         else begin isData = 1; mPhase = 8; end
      default: isData = 1;
    endcase
    exp = isData && (unl || !mProt[blk]);
  endtask

  task automatic doLoad(input logic [AW-1:0] a, input logic [7:0] d, input string req);
    bit exp;
    @(negedge clk);
    loadAddr = a; loadData = d; loadValid = 1'b1;
    modelLoad(a, d, exp);
    #1 check(req, {31'd0, commitOk}, {31'd0, exp});
    @(posedge clk);
    #1 loadValid = 1'b0;
  endtask

  task automatic checkOpen(input string req);
    @(negedge clk);
    check(req, {31'd0, writeAllowed}, {31'd0, (mPhase == 6 || mPhase == 7)});
  endtask

  task automatic endBurst(input string req);
    @(negedge clk);
    writeEnd = 1'b1;
    @(posedge clk);
    #1 writeEnd = 1'b0;
    mProt = (mProt | mPendSet) & ~mPendClr;
    mPendSet = '0; mPendClr = '0; mPhase = 0;
    @(negedge clk);
    check(req, 32'(blockProt), 32'(mProt));
    check("R9 allow low after end", {31'd0, writeAllowed}, 32'd0);
  endtask

  task automatic keySeq(input int b0, input int b1, input int b2);
    doLoad(mk(b0, 15'h5555), 8'hAA, "R5 key byte 1");
    doLoad(mk(b1, 15'h2AAA), 8'h55, "R5 key byte 2");
    doLoad(mk(b2, 15'h5555), 8'hA0, "R5 key byte 3");
  endtask

  task automatic relSeq(input int b);
    doLoad(mk(b, 15'h5555), 8'hAA, "R5 release 1");
    doLoad(mk(b, 15'h2AAA), 8'h55, "R5 release 2");
    doLoad(mk(b, 15'h5555), 8'h80, "R5 release 3");
    doLoad(mk(b, 15'h5555), 8'hAA, "R5 release 4");
    doLoad(mk(b, 15'h2AAA), 8'h55, "R5 release 5");
    doLoad(mk(b, 15'h5555), 8'h20, "R5 release 6");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5A17);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 reset prot", 32'(blockProt), 32'd0);
    check("R1 reset allow", {31'd0, writeAllowed}, 32'd0);

    // R6 unlocked block accepts data
    doLoad(mk(0, 15'h0123), 8'h11, "R6 open block");
    endBurst("R9 no change");

    // R2 key only, no data, lock block 2
    keySeq(2, 2, 2);
    checkOpen("R2 allow after key");
    check("R9 prot held before end", 32'(blockProt), 32'd0);
    endBurst("R2 block 2 locked");

    // R6 / R10 mixed blocks without key
    doLoad(mk(2, 15'h0040), 8'h77, "R6 locked block refused");
    doLoad(mk(3, 15'h0040), 8'h78, "R10 neighbour open");
    endBurst("R10 unchanged");

    // R4 key bytes across blocks, target from third byte; R7 data to locked block
    keySeq(0, 6, 5);
    doLoad(mk(2, 15'h0041), 8'h99, "R7 keyed data to locked block");
    doLoad(mk(5, 15'h0042), 8'h9A, "R7 keyed data to target block");
    endBurst("R4 block 5 locked");

    // R8 broken sequence, then key in same burst is plain data
    doLoad(mk(2, 15'h5555), 8'hAA, "R5 partial byte");
    doLoad(mk(2, 15'h2AAA), 8'h33, "R8 offending byte judged as data");
    doLoad(mk(7, 15'h5555), 8'hAA, "R8 later key is data");
    doLoad(mk(7, 15'h2AAA), 8'h55, "R8 later key is data");
    doLoad(mk(7, 15'h5555), 8'hA0, "R8 later key is data");
    checkOpen("R8 burst stays closed");
    endBurst("R8 block 7 stays open");

    // R3 release block 2
    relSeq(2);
    checkOpen("R3 allow after release");
    endBurst("R3 block 2 unlocked");

    // R9 burst ended mid-sequence
    doLoad(mk(5, 15'h5555), 8'hAA, "R5 partial");
    doLoad(mk(5, 15'h2AAA), 8'h55, "R5 partial");
    endBurst("R9 mid-sequence end no change");
    doLoad(mk(5, 15'h0100), 8'h01, "R9 block 5 still locked");
    endBurst("R9 no change");

    // random bursts
    for (int n = 0; n < 300; n++) begin
      int kind = int'($urandom_range(0, 3));
      int tgt = int'($urandom_range(0, NB - 1));
      int cnt = int'($urandom_range(0, 5));
      case (kind)
        1: keySeq(int'($urandom_range(0, NB - 1)), int'($urandom_range(0, NB - 1)), tgt);
        2: relSeq(tgt);
        3: begin
          doLoad(mk(tgt, 15'h5555), 8'hAA, "R5 random partial");
          doLoad(mk(tgt, 15'h2AAA), 8'($urandom_range(0, 255)), "R8 random break");
        end
        default: ;
      endcase
      for (int k = 0; k < cnt; k++) begin
        logic [14:0] low;
        logic [7:0]  dat;
        case ($urandom_range(0, 7))
          0: low = 15'h5555;
          1: low = 15'h2AAA;
          default: low = 15'($urandom);
        endcase
        case ($urandom_range(0, 5))
          0: dat = 8'hAA;
          1: dat = 8'h55;
          2: dat = 8'hA0;
          default: dat = 8'($urandom);
        endcase
        doLoad(mk(int'($urandom_range(0, NB - 1)), low), dat, "R6 R7 random load");
      end
      checkOpen("R2 R3 random allow");
      endBurst("R10 random prot");
    end

    summary();
  end

endmodule